// File: doc/BRIEF.md
# PCIe Host Address Window Decoder

This block holds the address window registers of a PCIe host bridge and decodes CPU addresses against them. Six windows are kept: a configuration window, a message window, three outbound memory windows and a register window. Each has a 64-bit base that is written as two 32-bit words, and a mask that sets both its enable and its size. Software programs the windows over a simple 32-bit register bus. The bridge logic behind this block presents each 64-bit CPU address and gets back which window claims it and the byte offset into that window.

The window's size is the two's complement of its mask with the enable bit (bit 0) cleared. The configuration window's size is limited to 256 MiB. A register-window mask of 0x7001 means a 4 KiB window. When windows overlap, the one that comes earliest in register order wins. Several instances may share one register bus; each decodes its own block of 23 words starting at the `REG_BASE` parameter (0x100 by default, 0x120 for a second bridge).

Top module: `pcie_win_decoder`

## Requirements
- R1: After a synchronous reset every register reads 0 and no window hits for any address.
- R2: Bus address `REG_BASE + k`, for k from 0 to 22, selects one 32-bit word. The words are, in order: cfg base hi, cfg base lo, cfg mask, msg base hi, msg base lo, msg mask, then for outbound windows 1, 2 and 3 the words base hi, base lo, mask hi, mask lo, then reg base hi, reg base lo, reg mask, special, control. A write at the rising edge with `bus_we` high stores `bus_wdata`. `bus_rdata` shows the addressed word combinationally. Addresses outside that range read 0, and writes to them change no word.
- R3: A write to one half of a 64-bit base or mask changes only that word; the other half keeps its value.
- R4: The configuration window is enabled by bit 0 of its mask. Its size is (2^32 - (mask & 0xFFFF_FFFE)) mod 2^32. The message window and the register window use the same 32-bit rule with their own masks.
- R5: A configuration window size greater than 0x1000_0000 (256 MiB) is clamped to 0x1000_0000.
- R6: A register-window mask equal to 0x0000_7001 gives an enabled 4096-byte window. Any other mask value uses the rule of R4.
- R7: An outbound window is enabled by bit 0 of its low mask word. Its size is (2^64 - ({mask hi, mask lo} & ~1)) mod 2^64.
- R8: A window hits when it is enabled and base <= cpu_addr < base + size, with the sum taken without overflow. `win_ofs` is cpu_addr - base for the winning window, and 0 when no window hits.
- R9: `win_hot` is one-hot or zero. Bit order is cfg=0, msg=1, outbound 1..3 = 2..4, reg=5. When several windows hit, the lowest index wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | BUS_AW (10) | Register bus word address |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Read data of the addressed word |
| cpu_addr | input | 64 | Address to decode |
| win_hot | output | 6 | One-hot winning window |
| win_ofs | output | 64 | Offset into the winning window |

## Verification
The assertions assume that reset is applied before the first use and that a write takes effect at the edge where `bus_we` is high. Later they read this as the masked word changing in that cycle and no other word changing. The bench changes the bus and CPU address signals shortly after a rising edge and holds them for a full cycle, so each write is a single clean strobe and each decode has settled before it is compared. The probe addresses sit at each window's first and last byte and one byte beyond each end, and on overlapping windows, so the edge comparisons and the priority order are both exercised.

// File: rtl/pcie_win_pkg.sv
package pcie_win_pkg;
    localparam int NREG      = 23;
    localparam int NDEC      = 21;
    localparam int NWIN      = 6;
    localparam int DW        = 32;
    localparam int AW        = 64;
    localparam int IW        = $clog2(NREG);
    localparam logic [AW-1:0] CFG_SPAN_MAX   = 64'h0000_0000_1000_0000;
    localparam logic [DW-1:0] REG_SMALL_CODE = 32'h0000_7001;
    localparam logic [AW-1:0] REG_SMALL_SPAN = 64'd4096;

    typedef logic [NREG-1:0][DW-1:0] regs_t;
    typedef logic [NDEC-1:0][DW-1:0] dec_regs_t;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] base;
        logic [AW-1:0] span;
    } win_t;

    typedef win_t [NWIN-1:0] win_vec_t;

    function automatic logic [AW-1:0] span_narrow(input logic [DW-1:0] m);
        logic [DW-1:0] t;
        t = ~(m & 32'hFFFF_FFFE) + 32'd1;
        return {32'b0, t};
    endfunction

    function automatic logic [AW-1:0] span_wide(input logic [AW-1:0] m);
        return ~(m & 64'hFFFF_FFFF_FFFF_FFFE) + 64'd1;
    endfunction

    function automatic win_vec_t decode_windows(input dec_regs_t r);
        win_vec_t w;
        logic [AW-1:0] s;
        w[0].en   = r[2][0];
        w[0].base = {r[0], r[1]};
        s         = span_narrow(r[2]);
        w[0].span = (s > CFG_SPAN_MAX) ? CFG_SPAN_MAX : s;
        w[1].en   = r[5][0];
        w[1].base = {r[3], r[4]};
        w[1].span = span_narrow(r[5]);
        for (int k = 0; k < 3; k++) begin
            w[2+k].en   = r[9+4*k][0];
            w[2+k].base = {r[6+4*k], r[7+4*k]};
            w[2+k].span = span_wide({r[8+4*k], r[9+4*k]});
        end
        w[5].en   = r[20][0];
        w[5].base = {r[18], r[19]};
        w[5].span = (r[20] == REG_SMALL_CODE) ? REG_SMALL_SPAN : span_narrow(r[20]);
        return w;
    endfunction
endpackage

// File: rtl/pcie_win_regfile.sv
module pcie_win_regfile
    import pcie_win_pkg::*;
#(
    parameter int              BUS_AW   = 10,
    parameter logic [BUS_AW-1:0] REG_BASE = 10'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [BUS_AW-1:0] addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    output regs_t             regs
);
    regs_t             regs_q;
    logic [BUS_AW-1:0] rel;
    logic              in_rng;

    assign rel    = addr - REG_BASE;
    assign in_rng = (addr >= REG_BASE) && (rel < BUS_AW'(NREG));

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (we && in_rng) begin
            regs_q[rel[IW-1:0]] <= wdata;
        end
    end

    assign rdata = in_rng ? regs_q[rel[IW-1:0]] : '0;
    assign regs  = regs_q;

    // A write stores to the addressed word only (R3).
    generate
        for (genvar j = 0; j < NREG; j++) begin : g_keep
            assert_half_only_R3: assert property (@(posedge clk) disable iff (rst)
                (we && in_rng && (rel != BUS_AW'(j))) |=> $stable(regs_q[j]));
        end
    endgenerate

    // Writes outside the block's range are dropped (R2).
    assert_stray_write_R2: assert property (@(posedge clk) disable iff (rst)
        (we && !in_rng) |=> $stable(regs_q));
endmodule

// File: rtl/pcie_win_match.sv
module pcie_win_match
    import pcie_win_pkg::*;
(
    input  win_vec_t                wins,
    input  logic [AW-1:0]           cpu_addr,
    output logic [NWIN-1:0]         raw_hit,
    output logic [NWIN-1:0][AW-1:0] ofs
);
    generate
        for (genvar i = 0; i < NWIN; i++) begin : g_cmp
            assign ofs[i]     = cpu_addr - wins[i].base;
            assign raw_hit[i] = wins[i].en && (cpu_addr >= wins[i].base) &&
                                (ofs[i] < wins[i].span);
        end
    endgenerate
endmodule

// File: rtl/pcie_win_prio.sv
module pcie_win_prio
    import pcie_win_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NWIN-1:0]         raw_hit,
    input  logic [NWIN-1:0][AW-1:0] ofs,
    output logic [NWIN-1:0]         win_hot,
    output logic [AW-1:0]           win_ofs
);
    always_comb begin
        win_hot = '0;
        win_ofs = '0;
        for (int i = NWIN - 1; i >= 0; i--) begin
            if (raw_hit[i]) begin
                win_hot    = '0;
                win_hot[i] = 1'b1;
                win_ofs    = ofs[i];
            end
        end
    end

    assert_onehot_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win_hot));

    assert_first_wins_R9: assert property (@(posedge clk) disable iff (rst)
        raw_hit[0] |-> win_hot[0]);

    assert_winner_hits_R8: assert property (@(posedge clk) disable iff (rst)
        (|raw_hit) |-> ((win_hot & raw_hit) != '0));
endmodule

// File: rtl/pcie_win_decoder.sv
module pcie_win_decoder
    import pcie_win_pkg::*;
#(
    parameter int              BUS_AW   = 10,
    parameter logic [BUS_AW-1:0] REG_BASE = 10'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_we,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    input  logic [AW-1:0]     cpu_addr,
    output logic [NWIN-1:0]   win_hot,
    output logic [AW-1:0]     win_ofs
);
    regs_t                   regs;
    dec_regs_t               dec_regs;
    win_vec_t                wins;
    logic [NWIN-1:0]         raw_hit;
    logic [NWIN-1:0][AW-1:0] ofs;

    pcie_win_regfile #(.BUS_AW(BUS_AW), .REG_BASE(REG_BASE)) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (bus_we),
        .addr  (bus_addr),
        .wdata (bus_wdata),
        .rdata (bus_rdata),
        .regs  (regs)
    );

    assign dec_regs = regs[NDEC-1:0];
    assign wins     = decode_windows(dec_regs);

    pcie_win_match u_match (
        .wins     (wins),
        .cpu_addr (cpu_addr),
        .raw_hit  (raw_hit),
        .ofs      (ofs)
    );

    pcie_win_prio u_prio (
        .clk     (clk),
        .rst     (rst),
        .raw_hit (raw_hit),
        .ofs     (ofs),
        .win_hot (win_hot),
        .win_ofs (win_ofs)
    );

    // The configuration window never exceeds its cap (R5).
    assert_cfg_clamp_R5: assert property (@(posedge clk) disable iff (rst)
        wins[0].span <= CFG_SPAN_MAX);
endmodule

// File: tb/pcie_win_decoder_test.sv
module pcie_win_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] RB = 10'h100;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] cpu_addr = '0;
    logic [5:0]  win_hot;
    logic [63:0] win_ofs;

    int    n_vec = 0;
    int    n_bad = 0;
    int    cyc = 0;
    string phase = "R1";
    logic [31:0] model [23];

    always #(CLK_PERIOD/2) clk = ~clk;

    pcie_win_decoder uut (
        .clk(clk), .rst(rst), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_addr(cpu_addr),
        .win_hot(win_hot), .win_ofs(win_ofs)
    );

    // Reference register model
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 23; i++) model[i] = 32'h0;
        end else if (bus_we && bus_addr >= RB && bus_addr < RB + 10'd23) begin
            model[bus_addr - RB] = bus_wdata;
        end
    end

    function automatic logic [31:0] exp_read(input logic [9:0] a);
        if (a >= RB && a < RB + 10'd23) return model[a - RB];
        return 32'h0;
    endfunction

    function automatic logic [63:0] small_size(input logic [31:0] m);
        logic [32:0] t;
        t = 33'h1_0000_0000 - {1'b0, m & 32'hFFFF_FFFE};
        return {32'h0, t[31:0]};
    endfunction

    task automatic exp_decode(input logic [63:0] a, output logic [5:0] hot,
                              output logic [63:0] o);
        logic [63:0] lo [6];
        logic [63:0] sz [6];
        bit          en [6];
        logic [64:0] t;
        bit          found;
        en[0] = model[2][0];  lo[0] = {model[0], model[1]};
        sz[0] = small_size(model[2]);
        if (sz[0] > 64'h1000_0000) sz[0] = 64'h1000_0000;
        en[1] = model[5][0];  lo[1] = {model[3], model[4]};
        sz[1] = small_size(model[5]);
        for (int k = 0; k < 3; k++) begin
            en[2+k] = model[9+4*k][0];
            lo[2+k] = {model[6+4*k], model[7+4*k]};
            t = 65'h1_0000_0000_0000_0000 -
                {1'b0, model[8+4*k], model[9+4*k] & 32'hFFFF_FFFE};
            sz[2+k] = t[63:0];
        end
        en[5] = model[20][0]; lo[5] = {model[18], model[19]};
        sz[5] = (model[20] == 32'h7001) ? 64'd4096 : small_size(model[20]);
        hot = '0; o = '0; found = 0;
        for (int i = 0; i < 6; i++) begin
            if (!found && en[i] && a >= lo[i] &&
                {1'b0, a} < ({1'b0, lo[i]} + {1'b0, sz[i]})) begin
                found = 1; hot[i] = 1'b1; o = a - lo[i];
            end
        end
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    // Compare on every falling edge, after reset has been applied once
    always @(negedge clk) begin
        logic [5:0]  eh;
        logic [63:0] eo;
        logic [31:0] er;
        bit          bad;
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            $display("FAIL watchdog: run hung (got running, expected done)");
            finish_run();
        end
        if (cyc > 2) begin
            bad = 0;
            er = exp_read(bus_addr);
            exp_decode(cpu_addr, eh, eo);
            if (bus_rdata !== er) begin
                bad = 1;
                $display("FAIL %s rdata @%h: got %h expected %h", phase, bus_addr, bus_rdata, er);
            end
            if (win_hot !== eh) begin
                bad = 1;
                $display("FAIL %s win_hot @%h: got %b expected %b", phase, cpu_addr, win_hot, eh);
            end
            if (win_ofs !== eo) begin
                bad = 1;
                $display("FAIL %s win_ofs @%h: got %h expected %h", phase, cpu_addr, win_ofs, eo);
            end
            n_vec++;
            if (bad) n_bad++;
        end
    end

    task automatic step;
        @(posedge clk); #1;
    endtask

    task automatic wr(input int k, input logic [31:0] d);
        step();
        bus_we = 1'b1; bus_addr = RB + 10'(k); bus_wdata = d;
        step();
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a);
        bus_addr = a; step();
    endtask

    task automatic probe(input logic [63:0] a);
        cpu_addr = a; step();
    endtask

    task automatic do_reset;
        step(); rst = 1'b1; step(); step(); rst = 1'b0;
    endtask

    initial begin
        // R1: reset state
        phase = "R1";
        step(); step(); rst = 1'b0;
        for (int k = 0; k < 23; k++) rd(RB + 10'(k));
        probe(64'h0); probe(64'hFFFF_FFFF_FFFF_FFFF); probe(64'h1_0000_0000);

        // R2: every word stores and reads back; stray writes dropped
        phase = "R2";
        for (int k = 0; k < 23; k++) wr(k, 32'hA500_0000 + 32'(k * 32'h0101_0102));
        for (int k = 0; k < 23; k++) rd(RB + 10'(k));
        step(); bus_we = 1'b1; bus_wdata = 32'hDEAD_BEEF;
        bus_addr = 10'h0FF; step(); bus_addr = 10'h117; step();
        bus_addr = 10'h120; step(); bus_addr = 10'h3FF; step();
        bus_we = 1'b0;
        for (int k = 0; k < 23; k++) rd(RB + 10'(k));
        rd(10'h0FF); rd(10'h117);

        phase = "R1";
        do_reset();
        for (int k = 0; k < 23; k++) rd(RB + 10'(k));
        probe(64'h0);

        // R3: halves are independent
        phase = "R3";
        wr(6, 32'h0000_0012); wr(7, 32'h3400_0000); wr(6, 32'h0000_0056);
        rd(RB + 10'd7); rd(RB + 10'd6);
        wr(9, 32'h0000_0001); wr(8, 32'hFFFF_FFFF);
        rd(RB + 10'd9); rd(RB + 10'd8);

        // R4: configuration window enable and 32-bit size rule
        phase = "R4";
        do_reset();
        wr(0, 32'h1); wr(1, 32'h4000_0000); wr(2, 32'hF000_0000);
        probe(64'h1_4000_0000);
        wr(2, 32'hFF00_0001);
        probe(64'h1_4000_0000); probe(64'h1_40FF_FFFF); probe(64'h1_4100_0000);
        probe(64'h1_3FFF_FFFF);
        wr(3, 32'h0); wr(4, 32'h9000_0000); wr(5, 32'hFFFF_0001);
        probe(64'h9000_0000); probe(64'h9000_FFFF); probe(64'h9001_0000);

        // R5: clamp of the configuration window to 256 MiB
        phase = "R5";
        wr(2, 32'hE000_0001);
        probe(64'h1_4FFF_FFFF); probe(64'h1_5000_0000); probe(64'h1_5FFF_FFFF);
        wr(2, 32'h0000_0001);
        probe(64'h1_4000_0000);

        // R6: register window special mask
        phase = "R6";
        wr(18, 32'h0); wr(19, 32'h2000_0000); wr(20, 32'h0000_7001);
        probe(64'h2000_0000); probe(64'h2000_0FFF); probe(64'h2000_1000);
        wr(20, 32'hFFFF_E001);
        probe(64'h2000_1FFF); probe(64'h2000_2000);
        wr(20, 32'h0000_7000);
        probe(64'h2000_0000);

        // R7: outbound window 64-bit mask
        phase = "R7";
        wr(10, 32'h8); wr(11, 32'h0); wr(12, 32'hFFFF_FFFF); wr(13, 32'h0000_0001);
        probe(64'h8_0000_0000); probe(64'h8_FFFF_FFFF); probe(64'h9_0000_0000);
        probe(64'h7_FFFF_FFFF);
        wr(12, 32'hFFFF_FFF0);
        probe(64'hF_FFFF_FFFF); probe(64'h18_0000_0000);

        // R9: overlapping windows, lowest index wins
        phase = "R9";
        wr(0, 32'h8); wr(1, 32'h0); wr(2, 32'hF000_0001);
        probe(64'h8_0000_0100); probe(64'h8_1000_0000);
        wr(14, 32'h8); wr(15, 32'h1000_0000); wr(16, 32'hFFFF_FFFF); wr(17, 32'hF000_0001);
        probe(64'h8_1000_0004);
        wr(6, 32'h8); wr(7, 32'h1000_0000); wr(8, 32'hFFFF_FFFF); wr(9, 32'hFF00_0001);
        probe(64'h8_1000_0004); probe(64'h8_1100_0000);

        // R8: offsets and edges across the programmed map
        phase = "R8";
        for (int i = 0; i < 200; i++) begin
            logic [63:0] a;
            a = {28'h0, 4'(i % 16), 32'($urandom)};
            probe(a);
        end
        probe(64'h0); probe(64'hFFFF_FFFF_FFFF_FFFF);

        finish_run();
    end
endmodule